// File: doc/BRIEF.md
# Descriptor Pointer Scheduler

This block sits on the register side of a descriptor-driven DMA write engine. Software queues work by writing the ID of the last descriptor it wants processed. Descriptor IDs run in a circular space whose highest ID is programmable. The block compares that target with its own progress and hands descriptor IDs to a downstream engine one at a time over a valid/ready handshake. It then waits for that engine to report each completion.

Completions arrive in order as single-cycle pulses. For each accepted completion the block can emit a one-cycle done-flag write strobe that carries the finished ID. It raises one interrupt pulse when the last requested descriptor of a batch is done. It also holds the 64-bit base address of the descriptor table, which is programmed in two 32-bit halves. The block has a plain 32-bit register port with word addresses 0 (base low), 1 (base high), 2 (table size), 3 (control) and 4 (last pointer).

Top module: `dma_ptr_ctrl`

## Requirements
- R1: While in reset and right after it, the table-size register reads 127, control reads 0, `base_valid_o`, `desc_valid_o` and `irq_o` are 0, and the last-pointer register reads 0xFF.
- R2: The first descriptor ID issued after reset is 0. Each later ID is the previous one plus one, and after the ID equal to the table-size value the next ID is 0.
- R3: A descriptor counts as issued only in a cycle where `desc_valid_o` and `desc_ready_i` are both high. While valid is high and ready is low, `desc_id_o` stays unchanged.
- R4: Writing L to the last-pointer register queues every ID after the previous last pointer up to and including L, in circular order. Writing the value already held queues nothing.
- R5: Reading the last-pointer register returns the last requested ID while any descriptor is outstanding, and returns 0xFF when nothing is outstanding.
- R6: While descriptors are outstanding, a further last-pointer write extends the batch. Writing the table-size value and then a small ID after the wrap produces one continuous run of IDs that crosses the wrap point.
- R7: The table-size register keeps the low 8 bits of a write and ignores writes while any descriptor is outstanding. A last-pointer write whose value is above the table size is ignored.
- R8: Control bit 0 enables done flags, and bits 31:1 read as 0. When the enable is set, an accepted completion produces `done_we_o` high for one cycle, starting the cycle after the pulse, with `done_id_o` set to the completed ID. When the enable is clear, no strobe appears.
- R9: Each batch produces exactly one `irq_o` pulse, one cycle long, in the cycle after the completion of the last requested descriptor.
- R10: A write to word 1 stores the high base half and clears `base_valid_o`. A write to word 0 stores the low half and sets `base_valid_o`. `base_o` equals {high, low}.
- R11: A completion pulse that arrives when no issued descriptor is awaiting completion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| desc_valid_o | output | 1 | Descriptor ID available |
| desc_id_o | output | 8 | Descriptor ID offered |
| desc_ready_i | input | 1 | Engine accepts the offered ID |
| cmpl_i | input | 1 | In-order completion pulse from engine |
| done_we_o | output | 1 | Done-flag write strobe |
| done_id_o | output | 8 | ID whose done flag is written |
| irq_o | output | 1 | End-of-batch interrupt pulse |
| base_o | output | 64 | Descriptor table base address |
| base_valid_o | output | 1 | Base address complete (low half written last) |

## Verification
On every cycle, the assertions check several local rules. The offered ID is held while the engine stalls. No ID is offered when nothing is outstanding. Done strobes occur only after a completion pulse with the enable set. The interrupt is a single-cycle pulse that lands when nothing is outstanding. The table size stays fixed while busy, and the base valid flag rises only on a low-half write. Other properties need the bench's scenarios: the exact circular order of IDs across the wrap, the count of IDs for each write, the extension of a batch while busy, the rejection of out-of-range or idle-equal writes, the ignoring of stray completions, and the single interrupt per batch.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_BASE_LO  = 3'd0,
    REG_BASE_HI  = 3'd1,
    REG_TBL_SIZE = 3'd2,
    REG_CTRL     = 3'd3,
    REG_LAST     = 3'd4
  } reg_sel_e;

  localparam logic [31:0] IDLE_READ = 32'h0000_00FF;
endpackage

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs
  import dma_ptr_pkg::*;
#(
  parameter int unsigned ID_W = 8,
  parameter int unsigned DW   = 32,
  parameter logic [ID_W-1:0] SIZE_RST = 8'd127
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              busy_i,
  input  logic [ID_W-1:0]   last_i,
  output logic [DW-1:0]     rdata_o,
  output logic [ID_W-1:0]   tbl_size_o,
  output logic              done_en_o,
  output logic [2*DW-1:0]   base_o,
  output logic              base_valid_o,
  output logic              last_wr_o,
  output logic [ID_W-1:0]   last_wdata_o
);
  logic [DW-1:0]   base_lo_q, base_hi_q;
  logic [ID_W-1:0] size_q;
  logic            done_en_q, base_valid_q;

  logic wr_lo, wr_hi, wr_size, wr_ctrl, wr_last;
  assign wr_lo   = wr_i && (addr_i == REG_BASE_LO);
  assign wr_hi   = wr_i && (addr_i == REG_BASE_HI);
  assign wr_size = wr_i && (addr_i == REG_TBL_SIZE) && !busy_i;
  assign wr_ctrl = wr_i && (addr_i == REG_CTRL);
  assign wr_last = wr_i && (addr_i == REG_LAST);

  // last pointer only accepted inside the ID space
  assign last_wr_o    = wr_last && (wdata_i[DW-1:ID_W] == '0) && (wdata_i[ID_W-1:0] <= size_q);
  assign last_wdata_o = wdata_i[ID_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_lo_q    <= '0;
      base_hi_q    <= '0;
      base_valid_q <= 1'b0;
      size_q       <= SIZE_RST;
      done_en_q    <= 1'b0;
    end else begin
      if (wr_hi) begin
        base_hi_q    <= wdata_i;
        base_valid_q <= 1'b0;
      end
      if (wr_lo) begin
        base_lo_q    <= wdata_i;
        base_valid_q <= 1'b1;
      end
      if (wr_size) size_q <= wdata_i[ID_W-1:0];
      if (wr_ctrl) done_en_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_BASE_LO:  rdata_o = base_lo_q;
      REG_BASE_HI:  rdata_o = base_hi_q;
      REG_TBL_SIZE: rdata_o[ID_W-1:0] = size_q;
      REG_CTRL:     rdata_o[0] = done_en_q;
      REG_LAST:     rdata_o = busy_i ? DW'(last_i) : IDLE_READ;
      default:      rdata_o = '0;
    endcase
  end

  assign tbl_size_o   = size_q;
  assign done_en_o    = done_en_q;
  assign base_o       = {base_hi_q, base_lo_q};
  assign base_valid_o = base_valid_q;

  p_size_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(size_q));
  p_base_commit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(base_valid_q) |-> $past(wr_i && (addr_i == REG_BASE_LO)));
  p_idle_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && addr_i == REG_LAST) |-> (rdata_o == IDLE_READ));
endmodule

// File: rtl/dma_ptr_seq.sv
module dma_ptr_seq #(
  parameter int unsigned ID_W = 8,
  parameter logic [ID_W-1:0] SIZE_RST = 8'd127
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] tbl_size_i,
  input  logic            last_wr_i,
  input  logic [ID_W-1:0] last_wdata_i,
  input  logic            done_en_i,
  input  logic            desc_ready_i,
  input  logic            cmpl_i,
  output logic            desc_valid_o,
  output logic [ID_W-1:0] desc_id_o,
  output logic            busy_o,
  output logic [ID_W-1:0] last_o,
  output logic            done_we_o,
  output logic [ID_W-1:0] done_id_o,
  output logic            irq_o
);
  function automatic logic [ID_W-1:0] id_next(input logic [ID_W-1:0] p, input logic [ID_W-1:0] top);
    return (p >= top) ? '0 : p + 1'b1;
  endfunction

  logic [ID_W-1:0] last_q, iss_q, cmp_q;
  logic [ID_W-1:0] last_d, cmp_nxt;
  logic            inflight, cmpl_ok, issue;

  assign busy_o       = (cmp_q != last_q);
  assign desc_valid_o = (iss_q != last_q);
  assign desc_id_o    = id_next(iss_q, tbl_size_i);
  assign inflight     = (cmp_q != iss_q);
  assign cmpl_ok      = cmpl_i && inflight;
  assign issue        = desc_valid_o && desc_ready_i;
  assign cmp_nxt      = id_next(cmp_q, tbl_size_i);
  assign last_d       = last_wr_i ? last_wdata_i : last_q;
  assign last_o       = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= SIZE_RST;
      iss_q     <= SIZE_RST;
      cmp_q     <= SIZE_RST;
      done_we_o <= 1'b0;
      done_id_o <= '0;
      irq_o     <= 1'b0;
    end else begin
      last_q <= last_d;
      if (issue) iss_q <= desc_id_o;
      if (cmpl_ok) cmp_q <= cmp_nxt;
      done_we_o <= cmpl_ok && done_en_i;
      done_id_o <= cmp_nxt;
      // an extension written in the same cycle defers the interrupt
      irq_o     <= cmpl_ok && (cmp_nxt == last_d);
    end
  end

  p_hold_id_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |=> $stable(desc_id_o));
  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !desc_valid_o);
  p_done_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_we_o |-> ($past(cmpl_i) && $past(done_en_i)));
  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_irq_drained_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o);
endmodule

// File: rtl/dma_ptr_ctrl.sv
module dma_ptr_ctrl
  import dma_ptr_pkg::*;
#(
  parameter int unsigned ID_W = 8,
  parameter int unsigned DW   = 32,
  parameter logic [ID_W-1:0] SIZE_RST = 8'd127
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              desc_valid_o,
  output logic [ID_W-1:0]   desc_id_o,
  input  logic              desc_ready_i,
  input  logic              cmpl_i,
  output logic              done_we_o,
  output logic [ID_W-1:0]   done_id_o,
  output logic              irq_o,
  output logic [2*DW-1:0]   base_o,
  output logic              base_valid_o
);
  logic [ID_W-1:0] tbl_size, last_ptr, last_wdata;
  logic            done_en, busy, last_wr;

  dma_ptr_regs #(.ID_W(ID_W), .DW(DW), .SIZE_RST(SIZE_RST)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .busy_i       (busy),
    .last_i       (last_ptr),
    .rdata_o      (reg_rdata_o),
    .tbl_size_o   (tbl_size),
    .done_en_o    (done_en),
    .base_o       (base_o),
    .base_valid_o (base_valid_o),
    .last_wr_o    (last_wr),
    .last_wdata_o (last_wdata)
  );

  dma_ptr_seq #(.ID_W(ID_W), .SIZE_RST(SIZE_RST)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tbl_size_i   (tbl_size),
    .last_wr_i    (last_wr),
    .last_wdata_i (last_wdata),
    .done_en_i    (done_en),
    .desc_ready_i (desc_ready_i),
    .cmpl_i       (cmpl_i),
    .desc_valid_o (desc_valid_o),
    .desc_id_o    (desc_id_o),
    .busy_o       (busy),
    .last_o       (last_ptr),
    .done_we_o    (done_we_o),
    .done_id_o    (done_id_o),
    .irq_o        (irq_o)
  );
endmodule

// File: tb/dma_ptr_ctrl_tb_top.sv
module dma_ptr_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        desc_valid_o;
  logic [7:0]  desc_id_o;
  logic        desc_ready_i = 1'b0;
  logic        cmpl_i = 1'b0;
  logic        done_we_o;
  logic [7:0]  done_id_o;
  logic        irq_o;
  logic [63:0] base_o;
  logic        base_valid_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  dma_ptr_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .desc_valid_o(desc_valid_o),
    .desc_id_o(desc_id_o), .desc_ready_i(desc_ready_i), .cmpl_i(cmpl_i),
    .done_we_o(done_we_o), .done_id_o(done_id_o), .irq_o(irq_o),
    .base_o(base_o), .base_valid_o(base_valid_o)
  );

  int n_chk = 0, n_fail = 0;
  bit eng_en = 0, force_cmpl = 0;
  int pend = 0, cyc = 0;
  logic [7:0] iss_log [64];
  logic [7:0] done_log [64];
  int iss_n = 0, done_n = 0, irq_n = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // engine model: everything on the falling edge
  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      pend = 0; cmpl_i = 1'b0; desc_ready_i = 1'b0;
    end else begin
      if (done_we_o) begin
        if (done_n < 64) done_log[done_n] = done_id_o;
        done_n++;
      end
      if (irq_o) irq_n++;
      cmpl_i = force_cmpl || (eng_en && pend > 0 && (cyc % 4 != 1));
      if (cmpl_i && !force_cmpl) pend--;
      desc_ready_i = eng_en && (cyc % 3 != 2);
      if (desc_valid_o && desc_ready_i) begin
        if (iss_n < 64) iss_log[iss_n] = desc_id_o;
        iss_n++;
        pend++;
      end
    end
  end

  task automatic clr_logs();
    iss_n = 0; done_n = 0; irq_n = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    #1;
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (!desc_valid_o && pend == 0) break;
    end
    repeat (3) @(negedge clk_i);
  endtask

  // register write/readback vectors: address, write data, expected read
  localparam int NV = 6;
  localparam logic [2:0]  V_ADDR [NV] = '{3'd3, 3'd3, 3'd2, 3'd2, 3'd1, 3'd0};
  localparam logic [31:0] V_WD   [NV] = '{32'hFFFF_FFFF, 32'h0, 32'h1F4, 32'd127, 32'hDEAD_BEEF, 32'h0000_1000};
  localparam logic [31:0] V_RD   [NV] = '{32'h1, 32'h0, 32'hF4, 32'd127, 32'hDEAD_BEEF, 32'h0000_1000};

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    rd(3'd2, 32'd127, "R1 size reset");
    rd(3'd3, 32'd0, "R1 ctrl reset");
    rd(3'd4, 32'hFF, "R1 last in reset");
    chk(!desc_valid_o && !irq_o && !base_valid_o, "R1 outputs in reset", {desc_valid_o, irq_o, base_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(3'd4, 32'hFF, "R1 last after reset");

    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WD[i]);
      rd(V_ADDR[i], V_RD[i], $sformatf("R7/R8/R10 vector %0d", i));
    end
    chk(base_o == 64'hDEAD_BEEF_0000_1000 && base_valid_o, "R10 base commit", base_o, 64'hDEAD_BEEF_0000_1000);
    wr(3'd1, 32'h1234_5678);
    chk(!base_valid_o, "R10 high write clears valid", base_valid_o, 0);
    wr(3'd0, 32'h9ABC_DEF0);
    chk(base_valid_o && base_o == 64'h1234_5678_9ABC_DEF0, "R10 low write commits", base_o, 64'h1234_5678_9ABC_DEF0);

    // batch A: IDs 0..4 with done flags, stall first
    wr(3'd3, 32'h1);
    clr_logs();
    wr(3'd4, 32'd4);
    rd(3'd4, 32'd4, "R5 last while busy");
    repeat (3) @(negedge clk_i);
    chk(desc_valid_o && desc_id_o == 8'd0, "R2 first id", desc_id_o, 0);
    chk(iss_n == 0, "R3 no issue without ready", iss_n, 0);
    eng_en = 1;
    wait_idle();
    chk(iss_n == 5, "R4 count batch A", iss_n, 5);
    for (int i = 0; i < 5; i++) chk(iss_log[i] == 8'(i), "R2 order batch A", iss_log[i], i);
    chk(done_n == 5, "R8 done count", done_n, 5);
    for (int i = 0; i < 5; i++) chk(done_log[i] == 8'(i), "R8 done id", done_log[i], i);
    chk(irq_n == 1, "R9 one irq batch A", irq_n, 1);
    rd(3'd4, 32'hFF, "R5 idle read");

    // batch B: wrap with extension while busy
    wr(3'd2, 32'd7);
    rd(3'd2, 32'd7, "R7 size idle write");
    clr_logs();
    wr(3'd4, 32'd7);
    wr(3'd2, 32'd3);
    wr(3'd4, 32'd1);
    rd(3'd2, 32'd7, "R7 size ignored busy");
    wait_idle();
    chk(iss_n == 5, "R6 count batch B", iss_n, 5);
    for (int i = 0; i < 5; i++)
      chk(iss_log[i] == 8'((i + 5) % 8), "R6 wrap order", iss_log[i], (i + 5) % 8);
    chk(irq_n == 1, "R9 one irq batch B", irq_n, 1);

    // out-of-range and equal writes
    clr_logs();
    wr(3'd4, 32'd9);
    rd(3'd4, 32'hFF, "R7 out-of-range last ignored");
    repeat (2) @(negedge clk_i);
    chk(!desc_valid_o && iss_n == 0, "R7 no issue after out-of-range", iss_n, 0);
    wr(3'd4, 32'd1);
    repeat (2) @(negedge clk_i);
    chk(!desc_valid_o && iss_n == 0, "R4 equal write queues none", iss_n, 0);
    rd(3'd4, 32'hFF, "R4 equal write idle");

    // batch D: done disabled
    wr(3'd3, 32'h0);
    clr_logs();
    wr(3'd4, 32'd3);
    wait_idle();
    chk(iss_n == 2 && iss_log[0] == 8'd2 && iss_log[1] == 8'd3, "R4 batch D ids", iss_n, 2);
    chk(done_n == 0, "R8 no done when disabled", done_n, 0);
    chk(irq_n == 1, "R9 one irq batch D", irq_n, 1);

    // R11 stray completion while idle
    eng_en = 0;
    wr(3'd3, 32'h1);
    clr_logs();
    force_cmpl = 1;
    @(negedge clk_i);
    force_cmpl = 0;
    repeat (3) @(negedge clk_i);
    chk(done_n == 0 && irq_n == 0, "R11 stray completion ignored", done_n + irq_n, 0);
    eng_en = 1;
    wr(3'd4, 32'd4);
    wait_idle();
    chk(iss_n == 1 && iss_log[0] == 8'd4, "R11 pointer unchanged", iss_log[0], 4);
    chk(done_n == 1 && done_log[0] == 8'd4 && irq_n == 1, "R11 single completion", done_log[0], 4);

    // reset mid-batch
    eng_en = 0;
    wr(3'd4, 32'd6);
    rd(3'd4, 32'd6, "R5 busy before reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    rd(3'd4, 32'hFF, "R5 reads FF in reset");
    rd(3'd2, 32'd127, "R1 size restored");
    chk(!desc_valid_o && !irq_o, "R1 quiet in reset", desc_valid_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    clr_logs();
    eng_en = 1;
    wr(3'd4, 32'd1);
    wait_idle();
    chk(iss_n == 2 && iss_log[0] == 8'd0 && iss_log[1] == 8'd1, "R2 ids restart after reset", iss_log[0], 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule